// File: doc/BRIEF.md
# Lane Polarity Inversion Detector

This block sits on the receive side of one serial lane, after the 8b/10b decoder and symbol aligner. During link training it watches the decoded stream for training ordered sets. Each set begins with a comma control symbol. The block reads the ten identifier symbols at positions 6 through 15 of each set. From their values it decides whether the two wires of the differential pair are swapped.

When a complete set shows the complemented identifier code, the block latches a polarity flag. From the next symbol onward it inverts every data byte it forwards. Control symbols pass through as they arrive. A one-cycle done pulse marks every set that produced a clean verdict, normal or inverted. The flag holds until a synchronous clear or reset. The surrounding training logic uses the pulse and the flag to move on. Later stages use the corrected byte stream.

Top module: `lane_pol_detect`

## Requirements
- R1: While reset is asserted and right after it is released, pol_inv, det_done and sym_out_vld are 0.
- R2: Each symbol accepted with sym_vld high appears on sym_out and sym_out_k one clock later, with sym_out_vld high. In a cycle with no accepted symbol, sym_out_vld is 0 and sym_out keeps its last value.
- R3: A data symbol (sym_is_k = 0) is forwarded XOR 0xFF when pol_inv was 1 in the cycle it was accepted, and unchanged otherwise. A control symbol is always forwarded unchanged.
- R4: A control symbol with byte 0xBC (comma) starts an ordered set at index 0. Every later accepted symbol raises the index by one, and indices 6 to 15 are the identifier field.
- R5: The set type is taken from index 6. Bytes 0x4A (normal) and 0xB5 (inverted) mark the first type. Bytes 0x45 (normal) and 0xBA (inverted) mark the second type. Any other byte at index 6 means the set produces no verdict.
- R6: If all ten identifier symbols equal the inverted code of their type, det_done and pol_inv are both 1 one clock after index 15 is accepted. The index-15 symbol is forwarded uncorrected, and the next data symbol is forwarded corrected.
- R7: If all ten identifier symbols equal the normal code of their type, det_done pulses one clock after index 15 is accepted, and pol_inv keeps its value.
- R8: A set whose identifier symbols mix normal and inverted codes, or mix the codes of both types, gives no det_done and leaves pol_inv unchanged.
- R9: A control symbol other than 0xBC at index 1 to 15 aborts the set, so no verdict follows. A comma symbol inside a set restarts it at index 0.
- R10: While train_on is 0, no set is tracked and no verdict is given. Dropping train_on during a set aborts that set. Output correction per R3 continues.
- R11: pol_clr clears pol_inv at the next clock and aborts the current set. It takes priority over a verdict in the same cycle, so no det_done follows.
- R12: det_done is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sym_in | input | 8 | Decoded symbol byte |
| sym_is_k | input | 1 | 1 when sym_in is a control symbol |
| sym_vld | input | 1 | Symbol strobe |
| train_on | input | 1 | Link training in progress |
| pol_clr | input | 1 | Synchronous clear of the polarity flag |
| sym_out | output | 8 | Polarity-corrected symbol byte |
| sym_out_k | output | 1 | Control flag of sym_out |
| sym_out_vld | output | 1 | sym_out carries a new symbol |
| pol_inv | output | 1 | Latched lane inversion flag |
| det_done | output | 1 | One-cycle pulse for each set that produced a verdict |

## Verification
The assertions assume that the input controls are never X after reset. They also assume that sym_in is stable whenever sym_vld is high, and that pol_clr and train_on are driven synchronously to the clock. The pulse-spacing property further relies on every verdict needing a full set of sixteen accepted symbols. The bench drives all inputs at the falling edge from tasks. It keeps train_on and pol_clr as clean one-cycle or level changes. It inserts random idle cycles only by lowering sym_vld, so no symbol ever changes while it is being accepted.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  localparam int SYM_W = 8;

  localparam logic [SYM_W-1:0] COMMA_CODE = 8'hBC;
  localparam logic [SYM_W-1:0] TSA_NORM   = 8'h4A;
  localparam logic [SYM_W-1:0] TSB_NORM   = 8'h45;

  typedef enum logic [1:0] {
    OS_NONE = 2'd0,
    OS_TSA  = 2'd1,
    OS_TSB  = 2'd2
  } os_kind_e;

  function automatic logic [SYM_W-1:0] norm_code(input os_kind_e kind);
    return (kind == OS_TSB) ? TSB_NORM : TSA_NORM;
  endfunction

  function automatic logic [SYM_W-1:0] flip_code(input os_kind_e kind);
    return ~norm_code(kind);
  endfunction

  function automatic os_kind_e kind_of(input logic [SYM_W-1:0] b);
    if (b == TSA_NORM || b == ~TSA_NORM) return OS_TSA;
    if (b == TSB_NORM || b == ~TSB_NORM) return OS_TSB;
    return OS_NONE;
  endfunction

endpackage

// File: rtl/lpd_os_track.sv
module lpd_os_track
  import lpd_pkg::*;
#(
  parameter int LAST_IDX = 15,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             sym_is_k,
  input  logic             sym_vld,
  input  logic             train_on,
  input  logic             pol_clr,
  output logic             cur_vld,
  output logic [IDX_W-1:0] cur_idx
);

  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LAST_IDX);
  localparam logic [IDX_W-1:0] ONE_I  = IDX_W'(1);

  logic             in_set_q, in_set_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en;
  logic             is_comma;

  assign is_comma = sym_is_k && (sym_in == COMMA_CODE);
  assign en       = sym_vld || !train_on || pol_clr;
  assign cur_vld  = in_set_q && sym_vld && !sym_is_k && train_on && !pol_clr;
  assign cur_idx  = idx_q;

  always_comb begin
    in_set_d = in_set_q;
    idx_d    = idx_q;
    if (!train_on || pol_clr) begin
      in_set_d = 1'b0;
    end else if (sym_vld) begin
      if (is_comma) begin
        in_set_d = 1'b1;
        idx_d    = ONE_I;
      end else if (sym_is_k) begin
        in_set_d = 1'b0;
      end else if (in_set_q) begin
        if (idx_q == LAST_I) in_set_d = 1'b0;
        idx_d = idx_q + ONE_I;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_set_q <= 1'b0;
      idx_q    <= '0;
    end else if (en) begin
      in_set_q <= in_set_d;
      idx_q    <= idx_d;
    end
  end

endmodule

// File: rtl/lpd_id_vote.sv
module lpd_id_vote
  import lpd_pkg::*;
#(
  parameter int FIRST_IDX = 6,
  parameter int LAST_IDX  = 15,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_vld,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [SYM_W-1:0] sym_in,
  output logic             dec_vld,
  output logic             dec_inv
);

  localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(FIRST_IDX);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(LAST_IDX);

  os_kind_e kind_q, kind_d, kind_now;
  logic     nrm_ok_q, nrm_ok_d;
  logic     inv_ok_q, inv_ok_d;
  logic     at_first, in_field, at_last;
  logic     hit_nrm, hit_inv;

  assign at_first = cur_vld && (cur_idx == FIRST_I);
  assign in_field = cur_vld && (cur_idx >= FIRST_I) && (cur_idx <= LAST_I);
  assign at_last  = cur_vld && (cur_idx == LAST_I);

  always_comb begin
    kind_now = at_first ? kind_of(sym_in) : kind_q;
    hit_nrm  = (kind_now != OS_NONE) && (sym_in == norm_code(kind_now));
    hit_inv  = (kind_now != OS_NONE) && (sym_in == flip_code(kind_now));
    kind_d   = kind_now;
    nrm_ok_d = at_first ? hit_nrm : (nrm_ok_q && hit_nrm);
    inv_ok_d = at_first ? hit_inv : (inv_ok_q && hit_inv);
  end

  assign dec_vld = at_last && (nrm_ok_d || inv_ok_d);
  assign dec_inv = inv_ok_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= OS_NONE;
      nrm_ok_q <= 1'b0;
      inv_ok_q <= 1'b0;
    end else if (in_field) begin
      kind_q   <= kind_d;
      nrm_ok_q <= nrm_ok_d;
      inv_ok_q <= inv_ok_d;
    end
  end

endmodule

// File: rtl/lpd_flip_stage.sv
module lpd_flip_stage
  import lpd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             sym_is_k,
  input  logic             sym_vld,
  input  logic             flip,
  output logic [SYM_W-1:0] sym_out,
  output logic             sym_out_k,
  output logic             sym_out_vld
);

  logic [SYM_W-1:0] fixed;
  logic [SYM_W-1:0] out_q;
  logic             k_q, vld_q;
  logic             do_flip;

  assign do_flip = flip && !sym_is_k;

  for (genvar i = 0; i < SYM_W; i++) begin : g_bit
    assign fixed[i] = sym_in[i] ^ do_flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      k_q   <= 1'b0;
    end else if (sym_vld) begin
      out_q <= fixed;
      k_q   <= sym_is_k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= sym_vld;
  end

  assign sym_out     = out_q;
  assign sym_out_k   = k_q;
  assign sym_out_vld = vld_q;

endmodule

// File: rtl/lane_pol_detect.sv
module lane_pol_detect
  import lpd_pkg::*;
#(
  parameter int ID_FIRST = 6,
  parameter int ID_LAST  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             sym_is_k,
  input  logic             sym_vld,
  input  logic             train_on,
  input  logic             pol_clr,
  output logic [SYM_W-1:0] sym_out,
  output logic             sym_out_k,
  output logic             sym_out_vld,
  output logic             pol_inv,
  output logic             det_done
);

  localparam int IDX_W = $clog2(ID_LAST + 1);

  logic             cur_vld;
  logic [IDX_W-1:0] cur_idx;
  logic             dec_vld, dec_inv;
  logic             pol_q, pol_d;
  logic             done_q, done_d;

  lpd_os_track #(.LAST_IDX(ID_LAST), .IDX_W(IDX_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_in   (sym_in),
    .sym_is_k (sym_is_k),
    .sym_vld  (sym_vld),
    .train_on (train_on),
    .pol_clr  (pol_clr),
    .cur_vld  (cur_vld),
    .cur_idx  (cur_idx)
  );

  lpd_id_vote #(.FIRST_IDX(ID_FIRST), .LAST_IDX(ID_LAST), .IDX_W(IDX_W)) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur_vld (cur_vld),
    .cur_idx (cur_idx),
    .sym_in  (sym_in),
    .dec_vld (dec_vld),
    .dec_inv (dec_inv)
  );

  lpd_flip_stage u_flip (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_in      (sym_in),
    .sym_is_k    (sym_is_k),
    .sym_vld     (sym_vld),
    .flip        (pol_q),
    .sym_out     (sym_out),
    .sym_out_k   (sym_out_k),
    .sym_out_vld (sym_out_vld)
  );

  always_comb begin
    pol_d  = pol_q;
    done_d = dec_vld;
    if (pol_clr)                 pol_d = 1'b0;
    else if (dec_vld && dec_inv) pol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pol_q  <= pol_d;
      done_q <= done_d;
    end
  end

  assign pol_inv  = pol_q;
  assign det_done = done_q;

endmodule

// File: rtl/lpd_chk.sv
module lpd_chk
  import lpd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SYM_W-1:0] sym_in,
  input logic             sym_is_k,
  input logic             sym_vld,
  input logic             train_on,
  input logic             pol_clr,
  input logic [SYM_W-1:0] sym_out,
  input logic             sym_out_k,
  input logic             sym_out_vld,
  input logic             pol_inv,
  input logic             det_done
);

  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |=> sym_out_vld);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> (!sym_out_vld && $stable(sym_out)));

  p_k_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && sym_is_k) |=> (sym_out_k && sym_out == $past(sym_in)));

  p_d_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && !sym_is_k) |=> (sym_out == ($past(sym_in) ^ {SYM_W{$past(pol_inv)}})));

  p_rise_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_inv) |-> det_done);

  p_no_train_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !train_on |=> !det_done);

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pol_clr |=> (!pol_inv && !det_done));

  p_fall_needs_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pol_inv) |-> $past(pol_clr));

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |=> !det_done);

endmodule

bind lane_pol_detect lpd_chk u_chk (.*);

// File: tb/sim_lane_pol_detect.sv
`timescale 1ns/1ps
module sim_lane_pol_detect;

  localparam int K_NRM   = 0;
  localparam int K_INV   = 1;
  localparam int K_MIX   = 2;
  localparam int K_KAB   = 3;
  localparam int K_CROSS = 4;
  localparam int K_BAD   = 5;
  localparam int K_TDROP = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sym_in;
  logic       sym_is_k, sym_vld, train_on, pol_clr;
  logic [7:0] sym_out;
  logic       sym_out_k, sym_out_vld, pol_inv, det_done;

  int   total = 0;
  int   bad   = 0;
  logic exp_inv = 1'b0;
  logic [7:0] last_out;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  lane_pol_detect u0 (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .sym_is_k(sym_is_k),
    .sym_vld(sym_vld), .train_on(train_on), .pol_clr(pol_clr),
    .sym_out(sym_out), .sym_out_k(sym_out_k), .sym_out_vld(sym_out_vld),
    .pol_inv(pol_inv), .det_done(det_done)
  );

  task automatic chk(input logic ok, input string rq, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (ok !== 1'b1) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, a, e);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic k, input logic inv);
    return k ? b : (b ^ {8{inv}});
  endfunction

  task automatic put(input logic [7:0] b, input logic k, input logic exp_d,
                     input logic new_inv, input string rq);
    logic [7:0] eo;
    eo = exp_byte(b, k, exp_inv);
    sym_in = b; sym_is_k = k; sym_vld = 1'b1;
    @(negedge clk);
    sym_vld = 1'b0;
    exp_inv = new_inv;
    chk(sym_out_vld == 1'b1, "R2", 32'(sym_out_vld), 1);
    chk(sym_out == eo && sym_out_k == k, "R3", 32'(sym_out), 32'(eo));
    chk(det_done == exp_d, rq, 32'(det_done), 32'(exp_d));
    chk(pol_inv == exp_inv, rq, 32'(pol_inv), 32'(exp_inv));
    last_out = sym_out;
  endtask

  task automatic idle();
    sym_vld = 1'b0;
    @(negedge clk);
    chk(sym_out_vld == 1'b0 && sym_out == last_out, "R2", 32'(sym_out), 32'(last_out));
    chk(det_done == 1'b0, "R12", 32'(det_done), 0);
    chk(pol_inv == exp_inv, "R11", 32'(pol_inv), 32'(exp_inv));
  endtask

  task automatic clear_idle();
    pol_clr = 1'b1; sym_vld = 1'b0;
    @(negedge clk);
    pol_clr = 1'b0;
    exp_inv = 1'b0;
    chk(pol_inv == 1'b0 && det_done == 1'b0, "R11", 32'(pol_inv), 0);
  endtask

  task automatic send_set(input int kind, input logic tsb, input logic clr_last);
    logic [7:0] nc, ic, oc, b;
    logic bk, base, d, ni, set_train;
    int apos, mpos;
    string rq;
    nc = tsb ? 8'h45 : 8'h4A;
    ic = ~nc;
    oc = tsb ? 8'h4A : 8'h45;
    apos = 1 + int'($urandom % 15);
    mpos = 7 + int'($urandom % 9);
    base = 1'($urandom % 2);
    set_train = train_on;
    case (kind)
      K_MIX, K_CROSS: rq = "R8";
      K_BAD:          rq = "R5";
      K_KAB:          rq = "R9";
      K_TDROP:        rq = "R10";
      default:        rq = "R4";
    endcase
    if (!set_train) rq = "R10";
    put(8'hBC, 1'b1, 1'b0, exp_inv, "R4");
    for (int i = 1; i < 16; i++) begin
      bk = 1'b0;
      if (i < 6) b = 8'($urandom);
      else begin
        case (kind)
          K_NRM:   b = nc;
          K_MIX:   b = (i == mpos) ? (base ? nc : ic) : (base ? ic : nc);
          K_CROSS: b = (i == 6) ? nc : oc;
          default: b = ic;
        endcase
      end
      if (kind == K_BAD && i == 6) b = 8'h00;
      if (kind == K_KAB && i == apos) begin b = 8'h1C; bk = 1'b1; end
      if (kind == K_TDROP && i == 9) train_on = 1'b0;
      if (clr_last && i == 15) pol_clr = 1'b1;
      d  = (i == 15) && set_train && !clr_last && (kind == K_NRM || kind == K_INV);
      ni = (clr_last && i == 15) ? 1'b0 : ((d && kind == K_INV) ? 1'b1 : exp_inv);
      if (d) put(b, bk, d, ni, (kind == K_INV) ? "R6" : "R7");
      else   put(b, bk, d, ni, clr_last ? "R11" : rq);
      pol_clr = 1'b0;
      if (kind == K_TDROP && i == 9) train_on = 1'b1;
      if (i < 15 && ($urandom % 6) == 0) idle();
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; sym_in = '0; sym_is_k = 1'b0; sym_vld = 1'b0;
    train_on = 1'b1; pol_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(pol_inv == 1'b0 && det_done == 1'b0 && sym_out_vld == 1'b0, "R1",
        {29'd0, pol_inv, det_done, sym_out_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pol_inv == 1'b0 && det_done == 1'b0 && sym_out_vld == 1'b0, "R1",
        {29'd0, pol_inv, det_done, sym_out_vld}, 0);
    last_out = sym_out;

    send_set(K_NRM, 1'b0, 1'b0);   // R7 first type normal
    send_set(K_NRM, 1'b1, 1'b0);   // R7 second type normal
    send_set(K_INV, 1'b1, 1'b0);   // R6 inverted, flag rises
    put(8'h3C, 1'b0, 1'b0, 1'b1, "R6");  // data after verdict is corrected
    send_set(K_INV, 1'b0, 1'b0);   // R6 again while set
    send_set(K_NRM, 1'b0, 1'b0);   // R7 normal verdict keeps flag
    clear_idle();                  // R11
    send_set(K_MIX, 1'b0, 1'b0);   // R8
    send_set(K_CROSS, 1'b1, 1'b0); // R8
    send_set(K_BAD, 1'b0, 1'b0);   // R5
    send_set(K_KAB, 1'b1, 1'b0);   // R9
    send_set(K_TDROP, 1'b0, 1'b0); // R10
    train_on = 1'b0;
    send_set(K_INV, 1'b0, 1'b0);   // R10 no tracking
    train_on = 1'b1;
    put(8'hBC, 1'b1, 1'b0, exp_inv, "R9");
    put(8'h11, 1'b0, 1'b0, exp_inv, "R9");
    put(8'h22, 1'b0, 1'b0, exp_inv, "R9");
    send_set(K_INV, 1'b0, 1'b0);   // R9 restart by comma, then R6
    send_set(K_INV, 1'b1, 1'b1);   // R11 clear beats verdict

    for (int n = 0; n < 300; n++) begin
      train_on = (($urandom % 10) != 0);
      send_set(int'($urandom % 7), 1'($urandom % 2), (($urandom % 16) == 0));
      train_on = 1'b1;
      if (($urandom % 20) == 0) clear_idle();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule